// File: doc/BRIEF.md
# Multi-Requester Memory Bank Arbiter

This block lets six requesters share a group of memory banks. Two of the requesters are processor ports and four are I/O channel ports. Every bank runs its own access cycle. Requests that go to different banks therefore proceed in parallel. Requests that meet on one bank are served one at a time, and a round-robin pointer keeps any requester from being starved. Every access moves one 48-bit word.

The upper address bits pick the bank and the lower bits pick the word within it. A bank stays occupied for a fixed number of clock cycles. That number comes from a per-bank type mask, which chooses between a short cycle of 4 and a long cycle of 6.

A requester can mark its request as coming from a tape transfer. Each bank limits how many such tape requests it holds at once. The storage arrays are not part of the block: each bank drives a row, a write strobe and write data to its array, and takes back that array's read word combinationally.

Top module: `multibank_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it is released with no request raised, `gnt`, `done`, `stall` and `mem_wr` are all zero.
- R2: In a port's 7-bit address, bits [6:4] select the bank and bits [3:0] select the row. A read returns, on `rdata`, the 48-bit word last written at that bank and row.
- R3: Requests from different ports to different idle banks are all granted in the same cycle, so six banks can be busy at once.
- R4: A grant in cycle t gives `done` for that port in cycle t+4 on a bank whose `BANK_SLOW` bit is 0, and in cycle t+6 on a bank whose bit is 1. The bank grants again no earlier than the cycle after `done`.
- R5: A bank grants at most one port per cycle and holds a single access at a time. A waiting port is granted in the cycle that directly follows the current owner's `done`.
- R6: Among the ports waiting on one bank, the next grant goes to the first waiting port after the last granted port, counting upward by index and wrapping from 5 to 0.
- R7: `stall` equals `req & ~gnt`. A request with `tape` low, to a bank that is idle and that no other port is requesting, is granted in the same cycle `req` rises.
- R8: The tape requests pending on one bank never exceed two. Pending means waiting and admitted, or in service. A tape request is admitted at the clock edge after a slot is free, lowest port index first. It can be granted only from the following cycle onward, so a lone tape request to an idle bank is granted one cycle after it is raised.
- R9: A write (`we` = 1) stores `wdata` at its bank and row on the clock edge that ends its `done` cycle. `done` pulses for writes as well as reads, and `rdata` is meaningful only for reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 6 | Request per port, held until granted (ports 0-1 processors, 2-5 channels) |
| we | input | 6 | Write enable per port, held with req |
| tape | input | 6 | Marks the port's current request as tape-sourced |
| addr | input | 6*7 | Per-port address, port p at bits [7p+6:7p] |
| wdata | input | 6*48 | Per-port write word |
| gnt | output | 6 | Grant pulse, one cycle |
| stall | output | 6 | Request raised but not granted this cycle |
| done | output | 6 | Access completion pulse |
| rdata | output | 6*48 | Read word, valid with done |
| mem_wr | output | 8 | Write strobe per bank array |
| mem_row | output | 8*4 | Row address per bank array |
| mem_wdata | output | 8*48 | Write word per bank array |
| mem_rdata | input | 8*48 | Combinational read word from each bank array |

## Verification
Two functions can act in the same cycle: a grant on one bank, and the serialisation of waiters or the admission of tape requests on another bank. The bench provokes this in two ways. It fires six requests at six distinct banks together. It also holds a single bank busy while other ports are kept waiting on it, and while a third port gets an idle bank straight away. Every grant cycle is recorded, along with every completion, and each is compared with the cycle computed from the bank latency and the round-robin order. A scoreboard matches each completion and its read word against the access issued for that port.

// File: rtl/bank_arb_pkg.sv
// Shared sizes and types for the multi-bank arbiter.
// Assumes six ports: indices 0..NUM_CPU-1 are processors, the rest are channels.
package bank_arb_pkg;
    localparam int WORD_W     = 48;
    localparam int NUM_PORTS  = 6;
    localparam int NUM_CPU    = 2;
    localparam int PORT_IDX_W = $clog2(NUM_PORTS);

    typedef logic [NUM_PORTS-1:0] port_vec_t;
    typedef logic [WORD_W-1:0]    word_t;
endpackage

// File: rtl/tape_admit_gate.sv
// Per-bank admission gate for tape-sourced requests.
// Keeps the count of admitted waiting tape requests, plus the tape access in
// service, at or below CAP. Admits new tape requests lowest index first.
// Assumes a port holds req steady until granted, and targets one bank at a time.
module tape_admit_gate
    import bank_arb_pkg::*;
#(
    parameter int CAP = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  port_vec_t hit,        // ports requesting this bank
    input  port_vec_t tape,       // tape flag of each port's request
    input  port_vec_t gnt,        // this bank's grant this cycle
    input  logic      owner_tape, // a tape access is in service
    output port_vec_t adm         // admitted tape requests
);
    port_vec_t adm_q;
    port_vec_t adm_d;
    int        used;
    int        room;

    // Work out the free slots and admit new tape requests into them.
    always_comb begin
        used  = $countones(adm_q & hit) + int'(owner_tape);
        room  = CAP - used;
        adm_d = adm_q & hit & ~gnt;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (hit[i] && tape[i] && !adm_q[i] && room > 0) begin
                adm_d[i] = 1'b1;
                room     = room - 1;
            end
        end
    end

    // Register the admission set.
    always_ff @(posedge clk) begin
        if (!rst_n) adm_q <= '0;
        else        adm_q <= adm_d;
    end

    assign adm = adm_q;

    AST_TAPE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(adm_q & hit) + int'(owner_tape)) <= CAP);  // R8
endmodule

// File: rtl/bank_cycle_engine.sv
// One bank's cycle engine: round-robin pick among eligible ports, then an
// occupancy of LAT cycles. The last busy cycle raises done and the array write.
// Assumes the array answers reads combinationally from mem_row.
module bank_cycle_engine
    import bank_arb_pkg::*;
#(
    parameter  int ROW_W = 4,
    parameter  int LAT   = 4,
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  port_vec_t                     elig,
    input  port_vec_t                     tape,
    input  port_vec_t                     we,
    input  logic [NUM_PORTS*ROW_W-1:0]    row_all,
    input  logic [NUM_PORTS*WORD_W-1:0]   wdata_all,
    output port_vec_t                     gnt,
    output port_vec_t                     done,
    output logic                          busy,
    output logic                          owner_tape,
    output logic                          mem_wr,
    output logic [ROW_W-1:0]              mem_row,
    output word_t                         mem_wdata
);
    logic                  busy_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [PORT_IDX_W-1:0] own_q;
    logic [PORT_IDX_W-1:0] rr_q;
    logic                  we_q;
    logic                  tape_q;
    logic [ROW_W-1:0]      row_q;
    word_t                 wd_q;
    logic [PORT_IDX_W-1:0] pick;
    logic                  pick_ok;
    logic                  take;
    logic                  fin;
    int                    j;

    // Round-robin search, starting just after the last granted port.
    always_comb begin
        pick_ok = 1'b0;
        pick    = '0;
        j       = 0;
        for (int k = 1; k <= NUM_PORTS; k++) begin
            j = int'(rr_q) + k;
            if (j >= NUM_PORTS) j = j - NUM_PORTS;
            if (!pick_ok && elig[j]) begin
                pick_ok = 1'b1;
                pick    = PORT_IDX_W'(j);
            end
        end
    end

    assign take = pick_ok && !busy_q;
    assign fin  = busy_q && (cnt_q == '0);

    // Decode the grant and completion pulses.
    always_comb begin
        gnt  = '0;
        done = '0;
        if (take) gnt[pick]  = 1'b1;
        if (fin)  done[own_q] = 1'b1;
    end

    // Latch the winner's access and run down the occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            own_q  <= '0;
            rr_q   <= PORT_IDX_W'(NUM_PORTS - 1);
            we_q   <= 1'b0;
            tape_q <= 1'b0;
            row_q  <= '0;
            wd_q   <= '0;
        end else if (take) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LAT - 1);
            own_q  <= pick;
            rr_q   <= pick;
            we_q   <= we[pick];
            tape_q <= tape[pick];
            row_q  <= row_all[pick*ROW_W +: ROW_W];
            wd_q   <= wdata_all[pick*WORD_W +: WORD_W];
        end else if (busy_q) begin
            if (fin) busy_q <= 1'b0;
            else     cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy       = busy_q;
    assign owner_tape = busy_q && tape_q;
    assign mem_wr     = fin && we_q;
    assign mem_row    = row_q;
    assign mem_wdata  = wd_q;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));  // R5
    AST_GNT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> (busy_q && cnt_q == CNT_W'(LAT - 1)));  // R4
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> !busy_q);  // R4
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));  // R9
endmodule

// File: rtl/multibank_arbiter.sv
// Top of the multi-bank arbiter. It decodes each port's bank from the upper
// address bits, runs one admission gate and one cycle engine per bank, and
// merges the per-bank grants, completions and read words back onto the ports.
// Assumes each port holds req, we, tape, addr and wdata until gnt, and keeps
// at most one access outstanding.
module multibank_arbiter
    import bank_arb_pkg::*;
#(
    parameter  int                   NUM_BANKS = 8,
    parameter  int                   ROW_W     = 4,
    parameter  int                   FAST_CYC  = 4,
    parameter  int                   SLOW_CYC  = 6,
    parameter  logic [NUM_BANKS-1:0] BANK_SLOW = {(NUM_BANKS/2){2'b10}},
    parameter  int                   TAPE_CAP  = 2,
    localparam int                   BANK_W    = $clog2(NUM_BANKS),
    localparam int                   ADDR_W    = BANK_W + ROW_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          req,
    input  logic [NUM_PORTS-1:0]          we,
    input  logic [NUM_PORTS-1:0]          tape,
    input  logic [NUM_PORTS*ADDR_W-1:0]   addr,
    input  logic [NUM_PORTS*WORD_W-1:0]   wdata,
    output logic [NUM_PORTS-1:0]          gnt,
    output logic [NUM_PORTS-1:0]          stall,
    output logic [NUM_PORTS-1:0]          done,
    output logic [NUM_PORTS*WORD_W-1:0]   rdata,
    output logic [NUM_BANKS-1:0]          mem_wr,
    output logic [NUM_BANKS*ROW_W-1:0]    mem_row,
    output logic [NUM_BANKS*WORD_W-1:0]   mem_wdata,
    input  logic [NUM_BANKS*WORD_W-1:0]   mem_rdata
);
    logic [BANK_W-1:0]          bank_of [NUM_PORTS];
    logic [NUM_PORTS*ROW_W-1:0] row_all;
    port_vec_t                  hit_a  [NUM_BANKS];
    port_vec_t                  gnt_b  [NUM_BANKS];
    port_vec_t                  done_b [NUM_BANKS];
    logic [NUM_BANKS-1:0]       busy_v;

    // Split every port address into a bank index and a row.
    always_comb begin
        row_all = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            bank_of[p]                  = addr[p*ADDR_W+ROW_W +: BANK_W];
            row_all[p*ROW_W +: ROW_W]   = addr[p*ADDR_W +: ROW_W];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        port_vec_t hit_l;
        port_vec_t adm_l;
        port_vec_t elig_l;
        logic      otape_l;

        // Ports whose request falls on this bank.
        always_comb begin
            for (int p = 0; p < NUM_PORTS; p++)
                hit_l[p] = req[p] && (bank_of[p] == BANK_W'(b));
        end

        assign hit_a[b] = hit_l;
        assign elig_l   = hit_l & (~tape | adm_l);

        tape_admit_gate #(
            .CAP        (TAPE_CAP)
        ) i_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit_l),
            .tape       (tape),
            .gnt        (gnt_b[b]),
            .owner_tape (otape_l),
            .adm        (adm_l)
        );

        bank_cycle_engine #(
            .ROW_W      (ROW_W),
            .LAT        (BANK_SLOW[b] ? SLOW_CYC : FAST_CYC)
        ) i_engine (
            .clk        (clk),
            .rst_n      (rst_n),
            .elig       (elig_l),
            .tape       (tape),
            .we         (we),
            .row_all    (row_all),
            .wdata_all  (wdata),
            .gnt        (gnt_b[b]),
            .done       (done_b[b]),
            .busy       (busy_v[b]),
            .owner_tape (otape_l),
            .mem_wr     (mem_wr[b]),
            .mem_row    (mem_row[b*ROW_W +: ROW_W]),
            .mem_wdata  (mem_wdata[b*WORD_W +: WORD_W])
        );
    end

    // Merge per-bank grants, completions and read words onto the ports.
    always_comb begin
        gnt   = '0;
        done  = '0;
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            gnt  = gnt  | gnt_b[b];
            done = done | done_b[b];
            for (int p = 0; p < NUM_PORTS; p++)
                if (done_b[b][p]) rdata[p*WORD_W +: WORD_W] = mem_rdata[b*WORD_W +: WORD_W];
        end
    end

    assign stall = req & ~gnt;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[p] |-> req[p]);  // R5
        if (p < NUM_CPU) begin : g_cpu
            AST_CPU_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
                (req[p] && !tape[p] && !busy_v[bank_of[p]]
                 && $countones(hit_a[bank_of[p]]) == 1) |-> gnt[p]);  // R7
        end
    end
endmodule

// File: tb/test_multibank_arbiter.sv
module test_multibank_arbiter;
    localparam int NP = 6;
    localparam int NB = 8;
    localparam int AW = 7;
    localparam int W  = 48;

    typedef struct { bit rd; logic [W-1:0] d; } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   req = '0, we = '0, tape = '0;
    logic [NP*AW-1:0] addr = '0;
    logic [NP*W-1:0] wdata = '0;
    logic [NP-1:0]   gnt, stall, done;
    logic [NP*W-1:0] rdata;
    logic [NB-1:0]   mem_wr;
    logic [NB*4-1:0] mem_row;
    logic [NB*W-1:0] mem_wdata, mem_rdata;

    logic [W-1:0] mem [NB][16];
    logic [W-1:0] shadow [128];
    exp_t         exp_q [NP][$];
    int           rcyc [NP], gcyc [NP], dcyc [NP];
    int           cyc = 0, n_chk = 0, n_fail = 0;

    multibank_arbiter i_multibank_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .tape(tape), .addr(addr),
        .wdata(wdata), .gnt(gnt), .stall(stall), .done(done), .rdata(rdata),
        .mem_wr(mem_wr), .mem_row(mem_row), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Bank array model: write on strobe, combinational read.
    always @(posedge clk) begin
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < 16; r++)
                if (!rst_n) mem[b][r] <= '0;
                else if (mem_wr[b] && mem_row[b*4 +: 4] == 4'(r)) mem[b][r] <= mem_wdata[b*W +: W];
    end
    always_comb
        for (int b = 0; b < NB; b++) mem_rdata[b*W +: W] = mem[b][mem_row[b*4 +: 4]];

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exv);
        end
    endtask

    function automatic logic [AW-1:0] mk(int b, int r);
        return {3'(b), 4'(r)};
    endfunction

    function automatic logic [W-1:0] pat(int p);
        return 48'hA5C3_0000_0000 ^ (48'(p) * 48'h0101_0101_0101);
    endfunction

    // Driver: raise a request, push its expected completion, hold until granted.
    task automatic access(int p, bit w, logic [AW-1:0] a, logic [W-1:0] d, bit t);
        exp_t e;
        @(negedge clk);
        req[p] = 1'b1; we[p] = w; tape[p] = t;
        addr[p*AW +: AW] = a; wdata[p*W +: W] = d;
        rcyc[p] = cyc;
        e.rd = !w; e.d = shadow[a];
        if (w) shadow[a] = d;
        exp_q[p].push_back(e);
        forever begin
            #1;
            if (gnt[p]) break;
            @(negedge clk);
        end
        gcyc[p] = cyc;
        @(posedge clk); #1;
        req[p] = 1'b0; we[p] = 1'b0; tape[p] = 1'b0;
    endtask

    // Monitor: pop the scoreboard on every completion and compare the read word.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (done[p]) begin
                    dcyc[p] = cyc;
                    if (exp_q[p].size() == 0) begin
                        check(1'b0, $sformatf("R9 unexpected done port %0d", p), 64'(p), 64'hFF);
                    end else begin
                        e = exp_q[p].pop_front();
                        if (e.rd)
                            check(rdata[p*W +: W] == e.d, $sformatf("R2 read data port %0d", p),
                                  64'(rdata[p*W +: W]), 64'(e.d));
                    end
                end
            end
        end
    end

    task automatic wait_idle();
        bit busy_tb;
        repeat (2) @(negedge clk);
        do begin
            busy_tb = 1'b0;
            for (int p = 0; p < NP; p++) if (exp_q[p].size() != 0) busy_tb = 1'b1;
            if (busy_tb) @(negedge clk);
        end while (busy_tb);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(gnt == 0 && done == 0, "R1 outputs during reset", 64'({gnt, done}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(gnt == 0, "R1 gnt after reset", 64'(gnt), 0);
        check(done == 0 && stall == 0, "R1 done/stall after reset", 64'({done, stall}), 0);
        check(mem_wr == 0, "R1 mem_wr after reset", 64'(mem_wr), 0);

        // R3, R4, R9: six writes to six banks at once.
        for (int p = 0; p < NP; p++) begin
            automatic int pp = p;
            fork access(pp, 1'b1, mk(pp, pp), pat(pp), 1'b0); join_none
        end
        wait fork;
        wait_idle();
        for (int p = 0; p < NP; p++) begin
            check(gcyc[p] == gcyc[0], $sformatf("R3 same-cycle grant port %0d", p), 64'(gcyc[p]), 64'(gcyc[0]));
            check(dcyc[p] - gcyc[p] == ((p % 2) ? 6 : 4), $sformatf("R4 latency bank %0d", p),
                  64'(dcyc[p] - gcyc[p]), 64'((p % 2) ? 6 : 4));
            check(mem[p][p] == pat(p), $sformatf("R9 R2 stored word bank %0d", p), 64'(mem[p][p]), 64'(pat(p)));
        end

        // R2: read back the six words in parallel.
        for (int p = 0; p < NP; p++) begin
            automatic int pp = p;
            fork access(pp, 1'b0, mk(pp, pp), '0, 1'b0); join_none
        end
        wait fork;
        wait_idle();

        // R5, R6: ports 0, 2, 5 on bank 2, where port 2 was granted last.
        fork
            access(0, 1'b0, mk(2, 2), '0, 1'b0);
            access(2, 1'b0, mk(2, 2), '0, 1'b0);
            access(5, 1'b0, mk(2, 2), '0, 1'b0);
        join
        wait_idle();
        check(gcyc[5] == rcyc[5], "R6 port 5 first", 64'(gcyc[5]), 64'(rcyc[5]));
        check(gcyc[0] == gcyc[5] + 5, "R6 R5 port 0 second", 64'(gcyc[0]), 64'(gcyc[5] + 5));
        check(gcyc[2] == gcyc[0] + 5, "R6 R5 port 2 third", 64'(gcyc[2]), 64'(gcyc[0] + 5));

        // R7: a stall on busy bank 3, while port 4 gets idle bank 6 at once.
        fork
            access(1, 1'b0, mk(3, 3), '0, 1'b0);
            begin @(negedge clk); access(0, 1'b1, mk(3, 1), 48'h0000_1234_5678, 1'b0); end
            access(4, 1'b0, mk(6, 0), '0, 1'b0);
            begin
                repeat (4) @(negedge clk); #1;
                check(stall[0] == 1'b1 && gnt[0] == 1'b0, "R7 stall while bank busy", 64'(stall[0]), 1);
            end
        join
        wait_idle();
        check(gcyc[4] == rcyc[4], "R7 immediate grant on idle bank", 64'(gcyc[4]), 64'(rcyc[4]));
        check(gcyc[0] == gcyc[1] + 7, "R5 R4 grant after slow done", 64'(gcyc[0]), 64'(gcyc[1] + 7));
        check(mem[3][1] == 48'h0000_1234_5678, "R9 write after stall", 64'(mem[3][1]), 64'h12345678);

        // R8: tape cap on bank 4 changes the order from round-robin 5,2,3 to 2,3,5.
        fork
            access(4, 1'b0, mk(4, 0), '0, 1'b1);
            begin
                repeat (2) @(negedge clk);
                fork
                    access(2, 1'b0, mk(4, 4), '0, 1'b1);
                    access(3, 1'b0, mk(4, 4), '0, 1'b1);
                    access(5, 1'b0, mk(4, 4), '0, 1'b1);
                join
            end
        join
        wait_idle();
        check(gcyc[4] == rcyc[4] + 1, "R8 tape admission delay", 64'(gcyc[4]), 64'(rcyc[4] + 1));
        check(gcyc[2] == gcyc[4] + 5, "R8 port 2 admitted first", 64'(gcyc[2]), 64'(gcyc[4] + 5));
        check(gcyc[3] == gcyc[4] + 10, "R8 port 3 second", 64'(gcyc[3]), 64'(gcyc[4] + 10));
        check(gcyc[5] == gcyc[4] + 15, "R8 port 5 held back by cap", 64'(gcyc[5]), 64'(gcyc[4] + 15));

        for (int p = 0; p < NP; p++)
            check(exp_q[p].size() == 0, $sformatf("R9 all completions seen port %0d", p), 64'(exp_q[p].size()), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule